// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a watchdog timer that sits behind a plain word-addressed register bus. A free-running up-counter advances on a slow tick strobe, either on every tick or once every 2^n ticks through a prescaler. If the counter runs past its all-ones value while the watchdog is armed, the block raises a one-cycle reset request and starts counting again from the load value. Software keeps the system alive by writing a trigger value that differs from the previous one. Each such write reloads the counter.

Bus writes are posted. Each write goes into a staging slot for its register and only takes effect a fixed number of ticks later. While a write is outstanding, the bit for that register stays set in a pending-status word. Arming and disarming the watchdog need a matched pair of key words written in order. A single stray write therefore cannot stop the timer.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the watchdog is armed and counting. The count, load value and control value are 0 and the pending word is 0. Reading word address 0 returns REVISION in bits 7:0. The read-only address map is: 0 revision, 1 control, 2 load, 3 count, 4 last trigger, 5 key (reads 0), 6 pending.
- R2: A bus write to control (1), load (2), trigger (4) or key (5) sets pending bit 0, 2, 3 or 4 respectively.
  - The bit clears on the POST_TICKS-th tick after the write. The new value takes effect on that same tick.
  - Until then, control and load read back their previous committed values.
  - Control keeps only bits 5:2; its other bits read 0.
- R3: Committing key 0xBBBB followed directly by key 0x4444 arms the watchdog.
- R4: Committing key 0xAAAA followed directly by key 0x5555 disarms the watchdog. While disarmed, the count holds.
- R5: If a first key word is followed by any other word, the sequence is abandoned and the armed state is unchanged. A new first word starts a fresh sequence.
- R6: Committing a trigger value that differs from the last committed trigger value loads the count from the committed load value and restarts the prescaler. The last trigger value is 0 after reset.
- R7: Committing a trigger value equal to the last one has no effect on the count.
- R8: With control bit 5 clear, an armed count advances by one on every tick.
- R9: With control bit 5 set, an armed count advances once every 2^v ticks, where v is control bits 4:2. The prescaler restarts when control commits.
- R10: When an armed count advances from all ones, reset_req_o is high for exactly one cycle and the count becomes the load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle slow time-base strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| reset_req_o | output | 1 | One-cycle reset request on overflow |

## Verification
The hardest case to reach from the ports is the moment a posted commit and a counter step land on the same tick. In that case the old arm or prescale setting still governs that step. The stimulus walks key pairs, trigger writes and control changes one tick at a time and reads the count back after each commit. To reach overflow in a short run, the bench builds the counter at 8 bits. It then loads 0xF0, so wrap-around and the single-cycle reset request are reached within a few dozen ticks.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int ADDR_W    = 3;
    localparam int NUM_SLOTS = 4;
    localparam int PEND_W    = 5;
    localparam int PTV_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_REV   = 3'd0,
        A_CTRL  = 3'd1,
        A_LOAD  = 3'd2,
        A_COUNT = 3'd3,
        A_TRIG  = 3'd4,
        A_KEY   = 3'd5,
        A_PEND  = 3'd6
    } addr_e;

    typedef enum logic [1:0] {
        KS_IDLE    = 2'd0,
        KS_ARM_ON  = 2'd1,
        KS_ARM_OFF = 2'd2
    } key_state_e;

    localparam logic [15:0] KEY_ON1  = 16'hBBBB;
    localparam logic [15:0] KEY_ON2  = 16'h4444;
    localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
    localparam logic [15:0] KEY_OFF2 = 16'h5555;

    // slot index order: control, load, trigger, key
    localparam int S_CTRL = 0;
    localparam int S_LOAD = 1;
    localparam int S_TRIG = 2;
    localparam int S_KEY  = 3;

    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        case (s)
            S_CTRL:  return A_CTRL;
            S_LOAD:  return A_LOAD;
            S_TRIG:  return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction

    function automatic int slot_pend_bit(input int s);
        case (s)
            S_CTRL:  return 0;
            S_LOAD:  return 2;
            S_TRIG:  return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/wdk_post_slot.sv
module wdk_post_slot #(
    parameter int DATA_W = 32,
    parameter int DELAY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              pend_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int DLY_W = $clog2(DELAY + 1);

    typedef struct packed {
        logic              pend;
        logic [DLY_W-1:0]  left;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_q, slot_d;

    always_comb begin
        slot_d   = slot_q;
        commit_o = slot_q.pend && tick_i && (slot_q.left == DLY_W'(1));
        if (slot_q.pend && tick_i) begin
            slot_d.left = slot_q.left - DLY_W'(1);
            if (slot_q.left == DLY_W'(1)) begin
                slot_d.pend = 1'b0;
            end
        end
        // a new write replaces the staged value and restarts the delay
        if (wr_i) begin
            slot_d.pend = 1'b1;
            slot_d.left = DLY_W'(DELAY);
            slot_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend_o = slot_q.pend;
    assign data_o = slot_q.data;

    assert_pend_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(wr_i));

    assert_pend_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_o) |-> $past(tick_i));

endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq import wdk_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              enable_o
);
    typedef struct packed {
        key_state_e st;
        logic       en;
    } ks_t;

    ks_t ks_q, ks_d;

    logic is_on1, is_on2, is_off1, is_off2;

    always_comb begin
        is_on1  = (word_i == DATA_W'(KEY_ON1));
        is_on2  = (word_i == DATA_W'(KEY_ON2));
        is_off1 = (word_i == DATA_W'(KEY_OFF1));
        is_off2 = (word_i == DATA_W'(KEY_OFF2));
        ks_d    = ks_q;
        if (commit_i) begin
            if (ks_q.st == KS_ARM_ON && is_on2) begin
                ks_d.en = 1'b1;
            end
            if (ks_q.st == KS_ARM_OFF && is_off2) begin
                ks_d.en = 1'b0;
            end
            if (is_on1) begin
                ks_d.st = KS_ARM_ON;
            end else if (is_off1) begin
                ks_d.st = KS_ARM_OFF;
            end else begin
                ks_d.st = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_q <= '{st: KS_IDLE, en: 1'b1};
        end else begin
            ks_q <= ks_d;
        end
    end

    assign enable_o = ks_q.en;

    assert_hold_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(enable_o));

    assert_arm_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_o) |-> $past(commit_i && is_on2 && ks_q.st == KS_ARM_ON));

    assert_disarm_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable_o) |-> $past(commit_i && is_off2 && ks_q.st == KS_ARM_OFF));

endmodule

// File: rtl/wdk_prescale.sv
module wdk_prescale import wdk_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pre_en_i,
    input  logic [PTV_W-1:0] ptv_i,
    input  logic             clr_i,
    output logic             adv_o
);
    localparam int DIV_W = (1 << PTV_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_t;

    ps_t ps_q, ps_d;
    logic [DIV_W-1:0] mask;
    logic             hit;

    always_comb begin
        mask  = DIV_W'((1 << ptv_i) - 1);
        hit   = (ps_q.div == mask);
        adv_o = tick_i && (!pre_en_i || hit);
        ps_d  = ps_q;
        if (clr_i) begin
            ps_d.div = '0;
        end else if (tick_i && pre_en_i) begin
            ps_d.div = hit ? '0 : ps_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assert_adv_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> tick_i);

    assert_div_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en_i && $stable(ptv_i) && !$past(clr_i) |-> ps_q.div <= mask);

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               adv_i,
    input  logic               reload_i,
    input  logic [COUNT_W-1:0] load_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               req_o
);
    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
        logic               req;
    } cn_t;

    cn_t cn_q, cn_d;

    always_comb begin
        cn_d     = cn_q;
        cn_d.req = 1'b0;
        if (reload_i) begin
            cn_d.cnt = load_i;
        end else if (en_i && adv_i) begin
            if (&cn_q.cnt) begin
                cn_d.req = 1'b1;
                cn_d.cnt = load_i;
            end else begin
                cn_d.cnt = cn_q.cnt + COUNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cn_q <= '0;
        end else begin
            cn_q <= cn_d;
        end
    end

    assign count_o = cn_q.cnt;
    assign req_o   = cn_q.req;

    assert_hold_disarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i && !reload_i |=> $stable(count_o));

    assert_req_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(en_i && adv_i && !reload_i));

    assert_req_wraps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> count_o == $past(load_i));

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt import wdk_pkg::*; #(
    parameter int         DATA_W     = 32,
    parameter int         COUNT_W    = 32,
    parameter int         POST_TICKS = 2,
    parameter logic [7:0] REVISION   = 8'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              reset_req_o
);
    typedef struct packed {
        logic [5:0]         ctrl;
        logic [COUNT_W-1:0] load;
        logic [DATA_W-1:0]  trig_last;
    } top_t;

    top_t top_q, top_d;

    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_commit;
    logic [DATA_W-1:0]    slot_data [NUM_SLOTS];
    logic [PEND_W-1:0]    pend_vec;
    logic                 reload_s;
    logic                 armed_s;
    logic                 adv_s;
    logic                 pre_clr_s;
    logic [COUNT_W-1:0]   count_s;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = bus_wr_i && (bus_addr_i == slot_addr(s));
        wdk_post_slot #(
            .DATA_W (DATA_W),
            .DELAY  (POST_TICKS)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .wr_i     (hit),
            .wdata_i  (bus_wdata_i),
            .pend_o   (slot_pend[s]),
            .commit_o (slot_commit[s]),
            .data_o   (slot_data[s])
        );
    end

    always_comb begin
        pend_vec = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            pend_vec[slot_pend_bit(s)] = slot_pend[s];
        end
    end

    always_comb begin
        reload_s  = slot_commit[S_TRIG] && (slot_data[S_TRIG] != top_q.trig_last);
        pre_clr_s = reload_s || slot_commit[S_CTRL];
        top_d     = top_q;
        if (slot_commit[S_CTRL]) begin
            top_d.ctrl = slot_data[S_CTRL][5:0] & 6'b111100;
        end
        if (slot_commit[S_LOAD]) begin
            top_d.load = slot_data[S_LOAD][COUNT_W-1:0];
        end
        if (reload_s) begin
            top_d.trig_last = slot_data[S_TRIG];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    wdk_keyseq #(
        .DATA_W (DATA_W)
    ) u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (slot_commit[S_KEY]),
        .word_i   (slot_data[S_KEY]),
        .enable_o (armed_s)
    );

    wdk_prescale u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .pre_en_i (top_q.ctrl[5]),
        .ptv_i    (top_q.ctrl[4:2]),
        .clr_i    (pre_clr_s),
        .adv_o    (adv_s)
    );

    wdk_counter #(
        .COUNT_W (COUNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (armed_s),
        .adv_i    (adv_s),
        .reload_i (reload_s),
        .load_i   (top_q.load),
        .count_o  (count_s),
        .req_o    (reset_req_o)
    );

    always_comb begin
        case (bus_addr_i)
            A_REV:   bus_rdata_o = DATA_W'(REVISION);
            A_CTRL:  bus_rdata_o = DATA_W'(top_q.ctrl);
            A_LOAD:  bus_rdata_o = DATA_W'(top_q.load);
            A_COUNT: bus_rdata_o = DATA_W'(count_s);
            A_TRIG:  bus_rdata_o = top_q.trig_last;
            A_PEND:  bus_rdata_o = DATA_W'(pend_vec);
            default: bus_rdata_o = '0;
        endcase
    end

    assert_trig_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload_s |=> count_s == $past(top_q.load));

    assert_same_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_commit[S_TRIG] && !reload_s |=> $stable(top_q.trig_last));

    assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_commit[S_LOAD] |=> !pend_vec[2] || $past(bus_wr_i));

endmodule

// File: tb/keyguard_wdt_bench.sv
module keyguard_wdt_bench;

    localparam logic [2:0] OP_WR = 3'd0;
    localparam logic [2:0] OP_TK = 3'd1;
    localparam logic [2:0] OP_RD = 3'd2;
    localparam logic [2:0] OP_RQ = 3'd3;
    localparam logic [2:0] OP_ID = 3'd4;

    localparam logic [2:0] AD_REV = 3'd0, AD_CTRL = 3'd1, AD_LOAD = 3'd2, AD_CNT = 3'd3,
                           AD_TRIG = 3'd4, AD_KEY = 3'd5, AD_PEND = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 57;
    localparam vec_t TBL [NV] = '{
        // R1 reset state
        '{OP_RD, AD_REV,  32'h0, 32'h3A, 4'd1},
        '{OP_RD, AD_CTRL, 32'h0, 32'h0,  4'd1},
        '{OP_RD, AD_LOAD, 32'h0, 32'h0,  4'd1},
        '{OP_RD, AD_CNT,  32'h0, 32'h0,  4'd1},
        '{OP_RD, AD_PEND, 32'h0, 32'h0,  4'd1},
        // R8 one step per tick
        '{OP_TK, AD_REV,  32'd3, 32'h0,  4'd8},
        '{OP_RD, AD_CNT,  32'h0, 32'd3,  4'd8},
        // R2 pending on key slot, R4 first word
        '{OP_WR, AD_KEY,  32'hAAAA, 32'h0, 4'd2},
        '{OP_RD, AD_PEND, 32'h0, 32'h10, 4'd2},
        '{OP_TK, AD_REV,  32'd1, 32'h0,  4'd2},
        '{OP_RD, AD_PEND, 32'h0, 32'h10, 4'd2},
        '{OP_TK, AD_REV,  32'd1, 32'h0,  4'd2},
        '{OP_RD, AD_PEND, 32'h0, 32'h0,  4'd2},
        '{OP_RD, AD_CNT,  32'h0, 32'd5,  4'd8},
        // R4 second word disarms; last step still counted
        '{OP_WR, AD_KEY,  32'h5555, 32'h0, 4'd4},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd4},
        '{OP_RD, AD_CNT,  32'h0, 32'd7,  4'd4},
        '{OP_TK, AD_REV,  32'd3, 32'h0,  4'd4},
        '{OP_RD, AD_CNT,  32'h0, 32'd7,  4'd4},
        // R5 broken arm sequence
        '{OP_WR, AD_KEY,  32'hBBBB, 32'h0, 4'd5},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd5},
        '{OP_WR, AD_KEY,  32'h1111, 32'h0, 4'd5},
        '{OP_TK, AD_REV,  32'd5, 32'h0,  4'd5},
        '{OP_RD, AD_CNT,  32'h0, 32'd7,  4'd5},
        // R3 proper arm pair
        '{OP_WR, AD_KEY,  32'hBBBB, 32'h0, 4'd3},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd3},
        '{OP_WR, AD_KEY,  32'h4444, 32'h0, 4'd3},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd3},
        '{OP_RD, AD_CNT,  32'h0, 32'd7,  4'd3},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd3},
        '{OP_RD, AD_CNT,  32'h0, 32'd9,  4'd3},
        // R2 load readback before and after commit
        '{OP_WR, AD_LOAD, 32'hF0, 32'h0, 4'd2},
        '{OP_RD, AD_LOAD, 32'h0, 32'h0,  4'd2},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd2},
        '{OP_RD, AD_LOAD, 32'h0, 32'hF0, 4'd2},
        // R6 new trigger reloads
        '{OP_WR, AD_TRIG, 32'h1234, 32'h0, 4'd6},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd6},
        '{OP_RD, AD_CNT,  32'h0, 32'hF0, 4'd6},
        // R7 same trigger ignored
        '{OP_WR, AD_TRIG, 32'h1234, 32'h0, 4'd7},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd7},
        '{OP_RD, AD_CNT,  32'h0, 32'hF2, 4'd7},
        // R6 inverted trigger reloads
        '{OP_WR, AD_TRIG, 32'hEDCB, 32'h0, 4'd6},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd6},
        '{OP_RD, AD_CNT,  32'h0, 32'hF0, 4'd6},
        // R10 overflow
        '{OP_TK, AD_REV,  32'd15, 32'h0, 4'd10},
        '{OP_RD, AD_CNT,  32'h0, 32'hFF, 4'd10},
        '{OP_RQ, AD_REV,  32'h0, 32'h0,  4'd10},
        '{OP_TK, AD_REV,  32'd1, 32'h0,  4'd10},
        '{OP_RQ, AD_REV,  32'h0, 32'h1,  4'd10},
        '{OP_RD, AD_CNT,  32'h0, 32'hF0, 4'd10},
        '{OP_ID, AD_REV,  32'd1, 32'h0,  4'd10},
        '{OP_RQ, AD_REV,  32'h0, 32'h0,  4'd10},
        // R9 prescaler /4; old setting governs the commit tick
        '{OP_WR, AD_CTRL, 32'h2B, 32'h0, 4'd9},
        '{OP_TK, AD_REV,  32'd2, 32'h0,  4'd9},
        '{OP_RD, AD_CTRL, 32'h0, 32'h28, 4'd2},
        '{OP_TK, AD_REV,  32'd3, 32'h0,  4'd9},
        '{OP_RD, AD_CNT,  32'h0, 32'hF2, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    keyguard_wdt #(
        .DATA_W     (32),
        .COUNT_W    (8),
        .POST_TICKS (2),
        .REVISION   (8'h3A)
    ) u_keyguard_wdt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .reset_req_o (req)
    );

    task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h", r, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd_chk(input int r, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(r, rdata, exp);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            case (TBL[k].op)
                OP_WR: do_wr(TBL[k].addr, TBL[k].data);
                OP_TK: do_tick(int'(TBL[k].data));
                OP_RD: rd_chk(int'(TBL[k].req), TBL[k].addr, TBL[k].exp);
                OP_RQ: chk(int'(TBL[k].req), {31'b0, req}, TBL[k].exp);
                default: repeat (int'(TBL[k].data)) @(negedge clk);
            endcase
        end
        // R9 fourth tick completes one prescaled step
        do_tick(1);
        rd_chk(9, AD_CNT, 32'hF3);
        // R2 all four pending bits at once; R7 same trigger keeps count
        do_wr(AD_CTRL, 32'h28);
        do_wr(AD_LOAD, 32'hF0);
        do_wr(AD_TRIG, 32'hEDCB);
        do_wr(AD_KEY, 32'h0);
        rd_chk(2, AD_PEND, 32'h1D);
        do_tick(2);
        rd_chk(2, AD_PEND, 32'h0);
        rd_chk(7, AD_CNT, 32'hF3);
        // R1 reset mid-run returns to armed, zero state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(1, AD_CNT, 32'h0);
        rd_chk(1, AD_CTRL, 32'h0);
        rd_chk(1, AD_TRIG, 32'h0);
        do_tick(2);
        rd_chk(1, AD_CNT, 32'd2);
        // R5 broken disarm sequence leaves the timer armed
        do_wr(AD_KEY, 32'hAAAA);
        do_tick(2);
        do_wr(AD_KEY, 32'h1234);
        do_tick(2);
        do_tick(1);
        rd_chk(5, AD_CNT, 32'd7);
        summary();
    end

endmodule